// File: doc/BRIEF.md
# Port PWM and blink generator

This block drives a bank of output ports from one reference clock. A single free-running prescaler provides two timebases at once. Its low five bits form a 32-clock PWM frame, and its upper bits supply a 50% blink square wave whose period is picked by a 3-bit rate field. Each port takes an 8-bit setting. The setting chooses a steady low level, a steady high level, or a PWM waveform whose duty is a count of sixteenths. A per-port blink flag can also gate the chosen waveform with the blink square wave.

The settings and the rate field are plain control inputs, not a stream, so there is no handshake and no back-pressure. The block samples them once per frame, on the last clock of each frame. The port levels come out of flops, so a port pin never sees a combinational glitch. The parameter `BLINK_MAX_LOG2` must be at least 9. With its default of 18 and a 32 kHz reference, the blink rates run from 0.125 Hz to 32 Hz and the PWM frame runs at 1024 Hz.

Top module: `port_pwm_blink`

## Requirements
- R1: The prescaler counts one per clock, and a PWM frame is 32 clocks long. When bit 6 of a setting is 0 and its duty field (bits 3:0) holds n in the range 1 to 15, the port is high for the first 2n clocks of the frame and low for the other 32-2n.
- R2: A setting with bit 6 equal to 0 and duty field 0000 drives a steady low level.
- R3: A setting with bit 6 equal to 1 drives a steady high level, whatever the duty field holds.
- R4: The blink period is 2^(B-c) clocks for rate code c from 0 to 6, and 2^(B-8) clocks for code 7, where B is `BLINK_MAX_LOG2`. With B = 18 this gives 262144 down to 4096 clocks, and then 1024 clocks.
- R5: When bit 7 of a setting is 1, the port follows its PWM or static level during the first half of each blink period and is held low during the second half. When bit 7 is 0, blink has no effect on the port.
- R6: Port settings and the rate field are sampled on the last clock of a frame and take effect from the first clock of the next frame. A change made in the middle of a frame has no effect before that boundary.
- R7: Reset clears the prescaler and every stored setting, so all ports are low. They stay low until the first frame boundary after reset is released.
- R8: Bits 5:4 of a setting are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| port_cfg | input | NUM_PORTS*8 | Settings, one byte per port; port k uses bits 8k+7:8k |
| blink_rate | input | 3 | Blink period select code |
| port_out | output | NUM_PORTS | Registered port levels |

## Verification
The bench builds the block with four ports and `BLINK_MAX_LOG2` = 13. With that value the slowest blink period is 8192 clocks and the fastest is 32 clocks. All eight rate codes can then be driven through two complete periods each within the run, and the period of every code is checked against the reference model. Four ports are enough to hold a PWM setting, a steady low, a steady high and a blinking setting side by side. Settings are also changed at scattered offsets inside frames, so that a change taking effect early or late is seen.

// File: rtl/pwmblk_pkg.sv
package pwmblk_pkg;
  localparam int DUTY_W     = 4;
  localparam int FRAME_LOG2 = DUTY_W + 1;
  localparam int CFG_W      = 8;
  localparam int RATE_W     = 3;
  localparam int RATE_CODES = 1 << RATE_W;

  typedef struct packed {
    logic              blink_en;
    logic              force_hi;
    logic [1:0]        unused;
    logic [DUTY_W-1:0] duty;
  } port_cfg_t;

  // Counter bit that carries the blink square wave for a rate code.
  function automatic int blink_tap(input int code, input int max_log2);
    if (code < RATE_CODES - 1) return max_log2 - 1 - code;
    return max_log2 - 9;
  endfunction
endpackage

// File: rtl/pwmblk_prescaler.sv
module pwmblk_prescaler
  import pwmblk_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             frame_last
);
  assign cnt_d      = cnt_q + 1'b1;
  assign frame_last = &cnt_q[FRAME_LOG2-1:0];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R1: a frame boundary is followed by position zero
  assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    frame_last |=> cnt_q[FRAME_LOG2-1:0] == '0);

  // R1: inside a frame the position steps by one per clock
  assert_frame_step_R1: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> cnt_q[FRAME_LOG2-1:0] == $past(cnt_q[FRAME_LOG2-1:0]) + 1'b1);
endmodule

// File: rtl/pwmblk_blink_sel.sv
module pwmblk_blink_sel
  import pwmblk_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [RATE_W-1:0] rate,
  output logic              blink_on
);
  logic [RATE_CODES-1:0] tap;
  logic [RATE_CODES-1:0] low_zero;

  for (genvar k = 0; k < RATE_CODES; k++) begin : g_tap
    localparam int IDX = blink_tap(k, CNT_W);
    assign tap[k] = cnt[IDX];
    if (IDX == 0) begin : g_no_low
      assign low_zero[k] = 1'b1;
    end else begin : g_low
      assign low_zero[k] = (cnt[IDX-1:0] == '0);
    end
  end

  // First half of the blink period passes the port level
  assign blink_on = ~tap[rate];

  // R4: the blink phase only moves when the lower counter bits wrap
  assert_blink_period_R4: assert property (@(posedge clk) disable iff (rst)
    ($stable(rate) && !low_zero[rate]) |-> (blink_on == $past(blink_on)));
endmodule

// File: rtl/pwmblk_lane.sv
module pwmblk_lane
  import pwmblk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_last,
  input  logic [CFG_W-1:0]      cfg_in,
  input  logic [FRAME_LOG2-1:0] pos_q,
  input  logic [FRAME_LOG2-1:0] pos_d,
  input  logic                  blink_on_d,
  output logic                  port_o
);
  port_cfg_t act_q, act_d;
  logic      level_d;

  assign act_d   = frame_last ? port_cfg_t'(cfg_in) : act_q;
  assign level_d = act_d.force_hi | (pos_d[FRAME_LOG2-1:1] < act_d.duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      port_o <= 1'b0;
    end else begin
      act_q  <= act_d;
      port_o <= level_d & (~act_d.blink_en | blink_on_d);
    end
  end

  // R6: stored setting only changes across a frame boundary
  assert_hold_midframe_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> $stable(act_q));

  // R2: duty zero without force-high is a steady low
  assert_static_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!act_q.force_hi && act_q.duty == '0) |-> !port_o);

  // R3: force-high without blink is a steady high
  assert_static_high_R3: assert property (@(posedge clk) disable iff (rst)
    (act_q.force_hi && !act_q.blink_en) |-> port_o);

  // R1: a nonzero duty is high at the start of the frame
  assert_pwm_start_R1: assert property (@(posedge clk) disable iff (rst)
    (!act_q.blink_en && act_q.duty != '0 && pos_q == '0) |-> port_o);
endmodule

// File: rtl/port_pwm_blink.sv
module port_pwm_blink
  import pwmblk_pkg::*;
#(
  parameter int NUM_PORTS      = 9,
  parameter int BLINK_MAX_LOG2 = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS*CFG_W-1:0] port_cfg,
  input  logic [RATE_W-1:0]          blink_rate,
  output logic [NUM_PORTS-1:0]       port_out
);
  localparam int CNT_W = BLINK_MAX_LOG2;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              frame_last;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              blink_on_d;

  pwmblk_prescaler #(.CNT_W(CNT_W)) u_prescaler (
    .clk        (clk),
    .rst        (rst),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d),
    .frame_last (frame_last)
  );

  assign rate_d = frame_last ? blink_rate : rate_q;

  always_ff @(posedge clk) begin
    if (rst) rate_q <= '0;
    else     rate_q <= rate_d;
  end

  pwmblk_blink_sel #(.CNT_W(CNT_W)) u_blink (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_d),
    .rate     (rate_d),
    .blink_on (blink_on_d)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    pwmblk_lane u_lane (
      .clk        (clk),
      .rst        (rst),
      .frame_last (frame_last),
      .cfg_in     (port_cfg[p*CFG_W +: CFG_W]),
      .pos_q      (cnt_q[FRAME_LOG2-1:0]),
      .pos_d      (cnt_d[FRAME_LOG2-1:0]),
      .blink_on_d (blink_on_d),
      .port_o     (port_out[p])
    );
  end

  // R6: rate field only changes across a frame boundary
  assert_rate_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> $stable(rate_q));
endmodule

// File: tb/port_pwm_blink_bench.sv
module port_pwm_blink_bench;
  localparam int NP = 4;
  localparam int B  = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP*8-1:0] port_cfg = '0;
  logic [2:0]    blink_rate = '0;
  logic [NP-1:0] port_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R7";
  bit done = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  port_pwm_blink #(.NUM_PORTS(NP), .BLINK_MAX_LOG2(B)) u_port_pwm_blink (
    .clk(clk), .rst(rst), .port_cfg(port_cfg),
    .blink_rate(blink_rate), .port_out(port_out)
  );

  // Behavioural reference
  int unsigned mcnt = 0;
  int          mrate = 0;
  logic [7:0]  macts [NP];
  logic [NP-1:0] mexp = '0;

  function automatic bit exp_bit(logic [7:0] c, int unsigned cnt, int rate);
    int pos = cnt % 32;
    int tap = (rate < 7) ? (B - 1 - rate) : (B - 9);
    bit lvl = c[6] || ((pos / 2) < c[3:0]);
    bit on  = ((cnt >> tap) & 1) == 0;
    return lvl && (!c[7] || on);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0; mrate = 0;
      for (int p = 0; p < NP; p++) macts[p] = 8'h00;
    end else begin
      if (mcnt % 32 == 31) begin
        mrate = blink_rate;
        for (int p = 0; p < NP; p++) macts[p] = port_cfg[p*8 +: 8];
      end
      mcnt = (mcnt + 1) % (1 << B);
    end
    for (int p = 0; p < NP; p++) mexp[p] = exp_bit(macts[p], mcnt, mrate);
    cmp_en = 1;
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      checks++;
      if (port_out !== mexp) begin
        errors++;
        $display("FAIL %s cnt %0d port_out %b expected %b", cur_req, mcnt, port_out, mexp);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [7:0] a, b, c, d);
    port_cfg = {d, c, b, a};
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    // R7: reset state, settings already presented
    set_cfg(8'h48, 8'h4F, 8'h08, 8'h0F);
    run(4);
    checks++;
    if (port_out !== '0) begin
      errors++;
      $display("FAIL R7 reset port_out %b expected 0000", port_out);
    end
    @(negedge clk) rst = 1'b0;
    cur_req = "R7";
    run(31);                      // first frame after reset stays low
    cur_req = "R1";
    set_cfg(8'h01, 8'h08, 8'h0F, 8'h05);
    run(96);
    cur_req = "R2";
    set_cfg(8'h00, 8'h30, 8'h01, 8'h00);
    run(96);
    cur_req = "R3";
    set_cfg(8'h40, 8'h4F, 8'h70, 8'h47);
    run(96);
    cur_req = "R8";
    set_cfg(8'h33, 8'h23, 8'h13, 8'h03);
    run(96);
    // R5 and R4: blink gating at every rate code
    for (int r = 0; r < 8; r++) begin
      cur_req = (r == 0) ? "R5" : "R4";
      blink_rate = 3'(r);
      set_cfg(8'hC0, 8'h88, 8'h40, 8'h8F);
      run(2 * (1 << ((r < 7) ? (B - r) : (B - 8))) + 64);
    end
    // R6: changes at scattered offsets inside frames
    cur_req = "R6";
    for (int k = 0; k < 24; k++) begin
      run((k * 7) % 32 + 1);
      set_cfg(8'(k * 37), 8'(k * 11 + 3), 8'(k ^ 8'h5A), 8'(k * 5));
      blink_rate = 3'((k + 5) % 8);
    end
    run(200);
    // R7: reset in mid-run
    cur_req = "R7";
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    run(64);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end
endmodule